// File: doc/BRIEF.md
# Power Island Ramp-Up Sequencer

This block drives the power switch, inrush limit and isolation controls of one power island and steps the island through a safe power-up or power-down. A power-up request first closes the switch at the lowest inrush limit. If power-good does not arrive within a fixed window, the block moves to the next higher limit. The limit stays at the first code that brings power-good.

Once the island reports good power, the block releases electrical isolation. It then runs a memory-repair handshake and finally releases functional isolation. If power-good never arrives, or repair does not finish in its window, the island is left off with every isolation applied, and an error pulse is raised.

Power-down applies the isolations in the reverse order of their release and then opens the switch. Requests are taken only while the sequencer is idle. The current control state is visible at all times as a 16-bit control-word image.

Top module: `pwr_ramp_seq`

## Requirements
- R1: After reset every control output, pulse and control-word bit is 0.
- R2: Control word layout: bit 0 switch closed, bit 1 power-good status, bit 2 electrical isolation released, bit 3 repair request, bit 4 repair-done status, bit 5 functional isolation released, bit 12 island enabled, bits 14:13 inrush code (0 = 3.5 mA, 1 = 5 mA, 2 = 10 mA, 3 = 20 mA); all other bits read 0.
- R3: A power-up request taken while idle with the switch open closes the switch with inrush code 0 in the next cycle. Each code is held for PG_WAIT_CYC cycles without power-good, and then the code rises by one.
- R4: The first cycle that sees power-good ends the ramp, and the inrush code in use at that point is kept.
- R5: If power-good is still absent when the window at code 3 ends, the switch opens, the code returns to 0, isolation stays applied and a one-cycle power-good timeout pulse is raised.
- R6: After power-good, electrical isolation is released in the next cycle. The repair request is raised in the cycle after that.
- R7: Repair-done seen within REP_WAIT_CYC cycles of the request drops the request, releases functional isolation, sets the enable bit and pulses done in the same cycle.
- R8: If repair-done is absent for REP_WAIT_CYC cycles, the request drops and electrical isolation is reapplied. One cycle later the switch opens, the code returns to 0 and a one-cycle repair-error pulse is raised.
- R9: A power-down request taken while the island is on clears functional isolation release and enable first. Electrical isolation release clears in the next cycle. The switch opens and the code clears in the cycle after that, together with the done pulse.
- R10: A power-up request with the switch already closed, or a power-down request with it already open, gives done in the next cycle and changes nothing else.
- R11: Requests that arrive while a sequence is running are ignored. Done, power-good timeout and repair error are one-cycle pulses, and no two of them are ever high together.
- R12: Control-word bits 1 and 4 show power-good and repair-done as they were sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req | input | 1 | Power-up request, taken only while idle |
| down_req | input | 1 | Power-down request, taken only while idle |
| pwr_good | input | 1 | Power-good from the island switch |
| repair_done | input | 1 | Completion from the memory repair engine |
| sw_on | output | 1 | Close the power switch |
| inrush_code | output | 2 | Inrush current limit code |
| eiso_rel | output | 1 | Release electrical isolation |
| fiso_rel | output | 1 | Release functional isolation |
| repair_req | output | 1 | Memory repair request |
| ctrl_word | output | 16 | Control-word image |
| done | output | 1 | Sequence completed pulse |
| pg_timeout | output | 1 | Power-good never arrived pulse |
| repair_err | output | 1 | Repair window expired pulse |

## Verification
Several ordering rules are checked on every cycle: the isolation hierarchy (functional release only with electrical release, electrical release and repair request only with the switch closed), the exclusivity of the result pulses, a steady inrush code inside a wait window, the step-by-one counting of the wait timers, and the status bits following their inputs. The bench scenarios are needed for the rest. These are the exact length of each inrush window, the code that is kept, the boundary where repair arrives in the last allowed cycle or one cycle too late, the cycle-by-cycle shutdown order, and the rule that mid-sequence requests and repeat requests have no effect.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int CTRL_W   = 16;
    localparam int INRUSH_W = 2;

    // control-word bit positions
    localparam int B_POWUP  = 0;
    localparam int B_PGOOD  = 1;
    localparam int B_EISO   = 2;
    localparam int B_MREP   = 3;
    localparam int B_MRDONE = 4;
    localparam int B_FISO   = 5;
    localparam int B_EN     = 12;
    localparam int B_INRUSH = 13;

    typedef logic [INRUSH_W-1:0] inrush_t;

    localparam inrush_t CODE_TOP = '1;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_RAMP   = 3'd1,
        S_EREL   = 3'd2,
        S_REPAIR = 3'd3,
        S_RFAIL  = 3'd4,
        S_DN_E   = 3'd5,
        S_DN_P   = 3'd6
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       powup;
        inrush_t    code;
        logic       eiso;
        logic       mrep;
        logic       fiso;
        logic       en;
        logic       done;
        logic       pg_to;
        logic       rep_err;
    } seq_regs_t;

endpackage

// File: rtl/pwr_wait_timer.sv
module pwr_wait_timer #(
    parameter int LIMIT = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = run && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run && !expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3
    counts_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && !expired) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      up_req,
    input  logic      down_req,
    input  logic      pwr_good,
    input  logic      repair_done,
    input  logic      pg_exp,
    input  logic      rep_exp,
    output logic      pg_run,
    output logic      pg_clr,
    output logic      rep_run,
    output logic      rep_clr,
    output seq_regs_t regs
);
    seq_regs_t r_d, r_q;

    assign regs    = r_q;
    assign pg_run  = (r_q.st == S_RAMP);
    assign pg_clr  = (r_q.st == S_IDLE) || ((r_q.st == S_RAMP) && pg_exp);
    assign rep_run = (r_q.st == S_REPAIR);
    assign rep_clr = (r_q.st != S_REPAIR);

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.pg_to   = 1'b0;
        r_d.rep_err = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (up_req) begin
                    if (r_q.powup) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.powup = 1'b1;
                        r_d.code  = '0;
                        r_d.st    = S_RAMP;
                    end
                end else if (down_req) begin
                    if (!r_q.powup) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.fiso = 1'b0;
                        r_d.en   = 1'b0;
                        r_d.st   = S_DN_E;
                    end
                end
            end
            S_RAMP: begin
                if (pwr_good) begin
                    r_d.eiso = 1'b1;
                    r_d.st   = S_EREL;
                end else if (pg_exp) begin
                    if (r_q.code == CODE_TOP) begin
                        r_d.powup = 1'b0;
                        r_d.code  = '0;
                        r_d.pg_to = 1'b1;
                        r_d.st    = S_IDLE;
                    end else begin
                        r_d.code = r_q.code + 1'b1;
                    end
                end
            end
            S_EREL: begin
                r_d.mrep = 1'b1;
                r_d.st   = S_REPAIR;
            end
            S_REPAIR: begin
                if (repair_done) begin
                    r_d.mrep = 1'b0;
                    r_d.fiso = 1'b1;
                    r_d.en   = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end else if (rep_exp) begin
                    r_d.mrep = 1'b0;
                    r_d.eiso = 1'b0;
                    r_d.st   = S_RFAIL;
                end
            end
            S_RFAIL: begin
                r_d.powup   = 1'b0;
                r_d.code    = '0;
                r_d.rep_err = 1'b1;
                r_d.st      = S_IDLE;
            end
            S_DN_E: begin
                r_d.eiso = 1'b0;
                r_d.st   = S_DN_P;
            end
            S_DN_P: begin
                r_d.powup = 1'b0;
                r_d.code  = '0;
                r_d.done  = 1'b1;
                r_d.st    = S_IDLE;
            end
            default: begin
                r_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R6
    eiso_needs_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.eiso |-> r_q.powup);

    // R7
    fiso_needs_eiso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.fiso |-> r_q.eiso);

    // R8
    repair_needs_eiso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.mrep |-> r_q.eiso);

    // R3
    code_steady_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_RAMP && !pwr_good && !pg_exp) |=> $stable(r_q.code));

    // R5
    timeout_switch_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pg_to |-> (!r_q.powup && !r_q.eiso && r_q.code == '0));

    // R11
    pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.done, r_q.pg_to, r_q.rep_err}));

endmodule

// File: rtl/pwr_ctrl_image.sv
module pwr_ctrl_image
    import pwr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              repair_done,
    input  seq_regs_t         regs,
    output logic [CTRL_W-1:0] word
);
    logic pg_stat_d, pg_stat_q;
    logic rd_stat_d, rd_stat_q;

    always_comb begin
        pg_stat_d = pwr_good;
        rd_stat_d = repair_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_stat_q <= 1'b0;
            rd_stat_q <= 1'b0;
        end else begin
            pg_stat_q <= pg_stat_d;
            rd_stat_q <= rd_stat_d;
        end
    end

    always_comb begin
        word                          = '0;
        word[B_POWUP]                 = regs.powup;
        word[B_PGOOD]                 = pg_stat_q;
        word[B_EISO]                  = regs.eiso;
        word[B_MREP]                  = regs.mrep;
        word[B_MRDONE]                = rd_stat_q;
        word[B_FISO]                  = regs.fiso;
        word[B_EN]                    = regs.en;
        word[B_INRUSH +: INRUSH_W]    = regs.code;
    end

    // R12
    pg_status_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good |=> word[B_PGOOD]);

    // R12
    pg_status_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !word[B_PGOOD]);

endmodule

// File: rtl/pwr_ramp_seq.sv
module pwr_ramp_seq
    import pwr_seq_pkg::*;
#(
    parameter int PG_WAIT_CYC  = 600,
    parameter int REP_WAIT_CYC = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        up_req,
    input  logic        down_req,
    input  logic        pwr_good,
    input  logic        repair_done,
    output logic        sw_on,
    output logic [1:0]  inrush_code,
    output logic        eiso_rel,
    output logic        fiso_rel,
    output logic        repair_req,
    output logic [15:0] ctrl_word,
    output logic        done,
    output logic        pg_timeout,
    output logic        repair_err
);
    seq_regs_t regs;
    logic pg_run, pg_clr, pg_exp;
    logic rep_run, rep_clr, rep_exp;

    pwr_wait_timer #(.LIMIT(PG_WAIT_CYC)) u_pg_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pg_clr),
        .run     (pg_run),
        .expired (pg_exp)
    );

    pwr_wait_timer #(.LIMIT(REP_WAIT_CYC)) u_rep_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rep_clr),
        .run     (rep_run),
        .expired (rep_exp)
    );

    pwr_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .up_req      (up_req),
        .down_req    (down_req),
        .pwr_good    (pwr_good),
        .repair_done (repair_done),
        .pg_exp      (pg_exp),
        .rep_exp     (rep_exp),
        .pg_run      (pg_run),
        .pg_clr      (pg_clr),
        .rep_run     (rep_run),
        .rep_clr     (rep_clr),
        .regs        (regs)
    );

    pwr_ctrl_image u_img (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_good    (pwr_good),
        .repair_done (repair_done),
        .regs        (regs),
        .word        (ctrl_word)
    );

    assign sw_on       = regs.powup;
    assign inrush_code = regs.code;
    assign eiso_rel    = regs.eiso;
    assign fiso_rel    = regs.fiso;
    assign repair_req  = regs.mrep;
    assign done        = regs.done;
    assign pg_timeout  = regs.pg_to;
    assign repair_err  = regs.rep_err;

endmodule

// File: tb/sim_pwr_ramp_seq.sv
`timescale 1ns/1ps
module sim_pwr_ramp_seq;
    localparam int N = 20;   // power-good window per inrush code
    localparam int M = 8;    // repair window
    localparam int K_DONE = 0, K_PGTO = 1, K_REPERR = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_req = 1'b0, down_req = 1'b0, pwr_good = 1'b0, repair_done = 1'b0;
    logic sw_on, eiso_rel, fiso_rel, repair_req, done, pg_timeout, repair_err;
    logic [1:0] inrush_code;
    logic [15:0] ctrl_word;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pwr_ramp_seq #(.PG_WAIT_CYC(N), .REP_WAIT_CYC(M)) u0 (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
        .pwr_good(pwr_good), .repair_done(repair_done), .sw_on(sw_on),
        .inrush_code(inrush_code), .eiso_rel(eiso_rel), .fiso_rel(fiso_rel),
        .repair_req(repair_req), .ctrl_word(ctrl_word), .done(done),
        .pg_timeout(pg_timeout), .repair_err(repair_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    // expected outcome from the requirements
    function automatic void predict(input int pg_at, input int rd_d,
                                    output int kind, output int cend, output int lvl);
        lvl = 0;
        if (pg_at - 1 >= 4 * N) begin
            kind = K_PGTO; cend = 4 * N + 1;
        end else begin
            lvl = (pg_at - 1) / N;
            if (rd_d <= M - 1) begin kind = K_DONE;   cend = pg_at + 3 + rd_d; end
            else               begin kind = K_REPERR; cend = pg_at + M + 3;    end
        end
    endfunction

    function automatic logic [31:0] on_word(input int lvl);
        return 32'h1 | 32'h2 | 32'h4 | 32'h10 | 32'h20 | 32'h1000 | (32'(lvl) << 13);
    endfunction

    task automatic power_down_check();
        down_req = 1'b1; nxt(); down_req = 1'b0;
        chk("R9 fiso cleared first", {30'b0, fiso_rel, ctrl_word[12]}, 32'h0);
        chk("R9 eiso still released", {30'b0, eiso_rel, sw_on}, 32'h3);
        nxt();
        chk("R9 eiso cleared second", {29'b0, eiso_rel, sw_on, done}, 32'h2);
        nxt();
        chk("R9 switch opened last", {29'b0, sw_on, inrush_code}, 32'h0);
        chk("R9 done pulse", {31'b0, done}, 32'h1);
        chk("R9 word after down", {16'b0, ctrl_word}, 32'h12);
        nxt();
        chk("R11 done one cycle", {31'b0, done}, 32'h0);
    endtask

    task automatic run_up(input int pg_at, input int rd_d, input bit try_repeat);
        int kind, cend, lvl, c, dc, got;
        bit seen;
        predict(pg_at, rd_d, kind, cend, lvl);
        seen = 1'b0; dc = 0; got = -1;
        up_req = 1'b1; nxt(); up_req = 1'b0;
        c = 1;
        chk("R3 ramp starts at code 0", {29'b0, sw_on, inrush_code}, 32'h4);
        while (c <= 6 * N + 2 * M) begin
            if (done || pg_timeout || repair_err) begin
                got = done ? K_DONE : (pg_timeout ? K_PGTO : K_REPERR);
                break;
            end
            if (c <= pg_at && c <= 4 * N)
                chk("R3 code per window", {30'b0, inrush_code}, 32'((c - 1) / N));
            if (kind != K_PGTO && c == pg_at + 1)
                chk("R6 eiso before repair", {30'b0, eiso_rel, repair_req}, 32'h2);
            if (kind != K_PGTO && c == pg_at + 2)
                chk("R6 repair request", {31'b0, repair_req}, 32'h1);
            if (c == pg_at) pwr_good = 1'b1;
            if (repair_req && !seen) begin seen = 1'b1; dc = 0; end
            if (seen) begin
                if (dc == rd_d) repair_done = 1'b1;
                dc++;
            end
            down_req = (c == 2);   // R11 ignored while busy
            up_req   = (c == 3);
            nxt();
            c++;
        end
        up_req = 1'b0; down_req = 1'b0;
        chk("R11 outcome kind", 32'(got), 32'(kind));
        chk("R11 completion cycle", 32'(c), 32'(cend));
        if (kind == K_DONE) begin
            chk("R4 R7 word when on", {16'b0, ctrl_word}, on_word(lvl));
        end else if (kind == K_PGTO) begin
            chk("R5 word after timeout", {16'b0, ctrl_word}, 32'h0);
        end else begin
            chk("R8 word after repair error", {16'b0, ctrl_word}, 32'h2);
        end
        nxt();
        chk("R11 pulses one cycle", {29'b0, done, pg_timeout, repair_err}, 32'h0);
        if (kind == K_DONE) begin
            if (try_repeat) begin
                up_req = 1'b1; nxt(); up_req = 1'b0;
                chk("R10 repeat up gives done", {31'b0, done}, 32'h1);
                chk("R10 repeat up no change", {16'b0, ctrl_word}, on_word(lvl));
                nxt();
            end
            power_down_check();
        end
        pwr_good = 1'b0; repair_done = 1'b0;
        nxt(); nxt();
    endtask

    initial begin
        #(5.0 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        nxt(); nxt();
        chk("R1 reset word", {16'b0, ctrl_word}, 32'h0);
        chk("R1 reset outputs", {24'b0, sw_on, inrush_code, eiso_rel, fiso_rel, repair_req, done, pg_timeout}, 32'h0);
        rst_n = 1'b1;
        nxt();
        chk("R1 idle after release", {16'b0, ctrl_word}, 32'h0);

        // R12 status mirrors
        pwr_good = 1'b1; nxt();
        chk("R12 pg status", {31'b0, ctrl_word[1]}, 32'h1);
        chk("R2 only status bit set", {16'b0, ctrl_word}, 32'h2);
        pwr_good = 1'b0; repair_done = 1'b1; nxt();
        chk("R12 rd status", {16'b0, ctrl_word}, 32'h10);
        repair_done = 1'b0; nxt();

        // R10 down while off
        down_req = 1'b1; nxt(); down_req = 1'b0;
        chk("R10 down while off done", {31'b0, done}, 32'h1);
        chk("R10 down while off no change", {16'b0, ctrl_word}, 32'h0);
        nxt();

        // directed corners
        run_up(1, 0, 1'b1);            // R4 code 0 immediately
        run_up(N, M - 1, 1'b0);        // R4 last cycle of code 0, R7 last repair cycle
        run_up(N + 1, 2, 1'b1);        // R3 step to code 1
        run_up(4 * N, 1, 1'b0);        // R4 last cycle of code 3
        run_up(4 * N + 1, 0, 1'b0);    // R5 timeout
        run_up(2 * N + 5, M + 1, 1'b0);// R8 repair window expires

        // constrained random
        for (int i = 0; i < 24; i++) begin
            int pg_at, rd_d;
            pg_at = 1 + int'($urandom % (4 * N + 4));
            if ($urandom % 4 == 0) rd_d = M + 1 + int'($urandom % 3);
            else                   rd_d = int'($urandom % M);
            run_up(pg_at, rd_d, ($urandom % 2) == 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule